// File: doc/BRIEF.md
# Register-File ALU with Compare Flags

This block is the arithmetic and logic datapath of a small sequential processor. A bank of general registers feeds two operands to a set of operation circuits. Each operation comes in with a valid strobe and an operation code. The first operand always comes from a register. The second operand comes either from a register or from an external data input, such as a value just fetched from memory. Add, subtract and the bitwise operations write their result back to a destination register on the clock edge that captures the operation.

A compare does not produce a result word. Instead it updates a three-flag condition register that says whether the first operand was greater than, equal to or less than the second. Exactly one flag is set at any time, and the flags keep their values until the next compare. A control unit asks whether a branch should be taken by placing a test code on `cond_sel`. The block evaluates that test against the stored flags and answers on `cond_true`, so a compare and a later conditional branch can be several operations apart.

A combinational read port (`rd_sel`/`rd_data`) lets the surrounding datapath read any register, for example to move a result out to memory.

Top module: `alu_ccr_top`

## Requirements
- R1: After reset every register reads 0 and the flag output `ccr_flags` is 3'b010, which means only the equal flag is set.
- R2: The ADD operation (code 0) writes (A + B) mod 2^W to the destination register.
- R3: The SUB operation (code 1) writes (A - B) mod 2^W to the destination register.
- R4: AND (code 2) writes A & B, OR (code 3) writes A | B, and NOT (code 4) writes ~A to the destination register.
- R5: When `use_ext_b` is 1, operand B is `ext_data`. When it is 0, operand B is the register selected by `srcb_sel`. Operand A is always the register selected by `srca_sel`.
- R6: COMPARE (code 5) compares A and B as unsigned numbers. It sets `ccr_flags` to 3'b100 when A > B, to 3'b010 when A == B and to 3'b001 when A < B. Bit 2 is greater, bit 1 is equal and bit 0 is less, and exactly one bit is ever set.
- R7: COMPARE writes no register, whatever `dst_sel` holds.
- R8: Only COMPARE changes `ccr_flags`. Every other operation leaves the flags as they were.
- R9: `cond_true` evaluates the test code on `cond_sel` against the stored flags: 0 = greater, 1 = equal, 2 = less, 3 = greater-or-equal, 4 = less-or-equal, 5 = not-equal. Codes 6 and 7 always give 0.
- R10: A cycle with `op_valid` low, or with a reserved operation code (6 or 7), changes neither the registers nor the flags.
- R11: A result appears on `rd_data` right after the clock edge that captures its operation. `rd_data` is a combinational read of the register selected by `rd_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 3 | Operation selector (0 add, 1 sub, 2 and, 3 or, 4 not, 5 compare) |
| dst_sel | input | $clog2(NREGS) | Destination register |
| srca_sel | input | $clog2(NREGS) | Register for operand A |
| srcb_sel | input | $clog2(NREGS) | Register for operand B |
| use_ext_b | input | 1 | Take operand B from ext_data |
| ext_data | input | DATA_W | External operand value |
| rd_sel | input | $clog2(NREGS) | Register shown on rd_data |
| rd_data | output | DATA_W | Contents of the selected register |
| cond_sel | input | 3 | Branch test code |
| cond_true | output | 1 | Result of the requested test |
| ccr_flags | output | 3 | Stored flags {greater, equal, less} |

## Verification
The assertions check on every cycle that the flags stay one-hot. They also check that the flags hold still unless a valid compare arrives, that the flags after a compare match the unsigned relation of the captured operands, that idle or compare cycles leave the register file untouched, and that the derived tests agree with the stored flags. Some properties only the bench scenarios can show. These are the arithmetic values at the wrap boundaries, the choice between the external operand and the register operand, and the reset contents. The bench covers them by sweeping every operand pair of a 4-bit configuration and checking each result against values it works out for itself.

// File: rtl/alu_ccr_pkg.sv
package alu_ccr_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_AND  = 3'd2,
        OP_OR   = 3'd3,
        OP_NOT  = 3'd4,
        OP_CMP  = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } alu_op_e;

    typedef enum logic [2:0] {
        TST_GT   = 3'd0,
        TST_EQ   = 3'd1,
        TST_LT   = 3'd2,
        TST_GE   = 3'd3,
        TST_LE   = 3'd4,
        TST_NE   = 3'd5,
        TST_RSV6 = 3'd6,
        TST_RSV7 = 3'd7
    } br_test_e;

    typedef struct packed {
        logic gt;
        logic eq;
        logic lt;
    } ccr_t;

    localparam ccr_t CCR_RESET = '{gt: 1'b0, eq: 1'b1, lt: 1'b0};

endpackage

// File: rtl/alu_regfile.sv
module alu_regfile
    import alu_ccr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NREGS  = 8,
    localparam int AW    = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     ra,
    input  logic [AW-1:0]     rb,
    input  logic [AW-1:0]     rc,
    output logic [DATA_W-1:0] da,
    output logic [DATA_W-1:0] db,
    output logic [DATA_W-1:0] dc
);

    logic [NREGS-1:0][DATA_W-1:0] regs_d, regs_q;
    logic [NREGS-1:0]             wsel;

    for (genvar i = 0; i < NREGS; i++) begin : g_wdec
        assign wsel[i] = we && (waddr == AW'(i));
    end

    always_comb begin
        for (int i = 0; i < NREGS; i++) begin
            regs_d[i] = wsel[i] ? wdata : regs_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign da = regs_q[ra];
    assign db = regs_q[rb];
    assign dc = regs_q[rc];

    // R7 / R10: no write strobe, no change anywhere in the bank
    assert_bank_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(regs_q));

    // R2: a strobed write lands in the addressed register
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> regs_q[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/alu_opunit.sv
module alu_opunit
    import alu_ccr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              valid,
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] result,
    output logic              wr_en,
    output logic              cmp_en,
    output ccr_t              cmp_flags
);

    always_comb begin
        result = '0;
        wr_en  = 1'b0;
        cmp_en = 1'b0;
        unique case (op)
            OP_ADD: begin result = a + b; wr_en = valid; end
            OP_SUB: begin result = a - b; wr_en = valid; end
            OP_AND: begin result = a & b; wr_en = valid; end
            OP_OR:  begin result = a | b; wr_en = valid; end
            OP_NOT: begin result = ~a;    wr_en = valid; end
            OP_CMP: cmp_en = valid;
            default: ;
        endcase
    end

    always_comb begin
        cmp_flags.gt = (a > b);
        cmp_flags.eq = (a == b);
        cmp_flags.lt = (a < b);
    end

endmodule

// File: rtl/alu_ccr_reg.sv
module alu_ccr_reg
    import alu_ccr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic upd,
    input  ccr_t flags_in,
    output ccr_t ccr
);

    typedef struct packed {
        ccr_t flags;
    } ccr_state_t;

    ccr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (upd) st_d.flags = flags_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{flags: CCR_RESET};
        else        st_q <= st_d;
    end

    assign ccr = st_q.flags;

    // R6: exactly one flag set at all times
    assert_ccr_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(st_q.flags) == 1);

    // R8: flags move only on a compare update
    assert_ccr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(st_q.flags));

endmodule

// File: rtl/alu_cond_eval.sv
module alu_cond_eval
    import alu_ccr_pkg::*;
(
    input  ccr_t     ccr,
    input  br_test_e test,
    output logic     taken
);

    always_comb begin
        unique case (test)
            TST_GT:  taken = ccr.gt;
            TST_EQ:  taken = ccr.eq;
            TST_LT:  taken = ccr.lt;
            TST_GE:  taken = ccr.gt | ccr.eq;
            TST_LE:  taken = ccr.lt | ccr.eq;
            TST_NE:  taken = ~ccr.eq;
            default: taken = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu_ccr_top.sv
module alu_ccr_top
    import alu_ccr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NREGS  = 8,
    localparam int AW    = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic [AW-1:0]     dst_sel,
    input  logic [AW-1:0]     srca_sel,
    input  logic [AW-1:0]     srcb_sel,
    input  logic              use_ext_b,
    input  logic [DATA_W-1:0] ext_data,
    input  logic [AW-1:0]     rd_sel,
    output logic [DATA_W-1:0] rd_data,
    input  logic [2:0]        cond_sel,
    output logic              cond_true,
    output logic [2:0]        ccr_flags
);

    alu_op_e           op;
    logic [DATA_W-1:0] opa, regb, opb, result;
    logic              wr_en, cmp_en;
    ccr_t              cmp_flags, ccr_q;

    assign op  = alu_op_e'(op_code);
    assign opb = use_ext_b ? ext_data : regb;

    alu_regfile #(.DATA_W(DATA_W), .NREGS(NREGS)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .waddr (dst_sel),
        .wdata (result),
        .ra    (srca_sel),
        .rb    (srcb_sel),
        .rc    (rd_sel),
        .da    (opa),
        .db    (regb),
        .dc    (rd_data)
    );

    alu_opunit #(.DATA_W(DATA_W)) u_ops (
        .valid     (op_valid),
        .op        (op),
        .a         (opa),
        .b         (opb),
        .result    (result),
        .wr_en     (wr_en),
        .cmp_en    (cmp_en),
        .cmp_flags (cmp_flags)
    );

    alu_ccr_reg u_ccr (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd      (cmp_en),
        .flags_in (cmp_flags),
        .ccr      (ccr_q)
    );

    alu_cond_eval u_cond (
        .ccr   (ccr_q),
        .test  (br_test_e'(cond_sel)),
        .taken (cond_true)
    );

    assign ccr_flags = ccr_q;

    // R6: after a compare the equal flag reflects the captured operands
    assert_cmp_eq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'd5) |=> ccr_flags[1] == ($past(opa) == $past(opb)));

    // R6: greater flag follows unsigned ordering
    assert_cmp_gt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'd5) |=> ccr_flags[2] == ($past(opa) > $past(opb)));

    // R9: greater-or-equal agrees with the stored flags
    assert_cond_ge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_sel == 3'd3) |-> cond_true == (ccr_flags[2] | ccr_flags[1]));

    // R9: not-equal agrees with the stored flags
    assert_cond_ne_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_sel == 3'd5) |-> cond_true == !ccr_flags[1]);

    // R9: reserved test codes never report taken
    assert_cond_rsv_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_sel[2:1] == 2'b11) |-> !cond_true);

endmodule

// File: tb/sim_alu_ccr_top.sv
`timescale 1ns/1ps
module sim_alu_ccr_top;

    localparam int W  = 4;
    localparam int N  = 4;
    localparam int AW = 2;
    localparam int M  = 1 << W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_valid = 1'b0;
    logic [2:0]    op_code = '0;
    logic [AW-1:0] dst_sel = '0, srca_sel = '0, srcb_sel = '0, rd_sel = '0;
    logic          use_ext_b = 1'b0;
    logic [W-1:0]  ext_data = '0;
    logic [W-1:0]  rd_data;
    logic [2:0]    cond_sel = '0;
    logic          cond_true;
    logic [2:0]    ccr_flags;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    logic [2:0] exp_ccr;

    always #2.5 clk = ~clk;

    alu_ccr_top #(.DATA_W(W), .NREGS(N)) u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .dst_sel(dst_sel), .srca_sel(srca_sel), .srcb_sel(srcb_sel),
        .use_ext_b(use_ext_b), .ext_data(ext_data), .rd_sel(rd_sel),
        .rd_data(rd_data), .cond_sel(cond_sel), .cond_true(cond_true),
        .ccr_flags(ccr_flags)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_op(input int code, input int dst, input int sa, input int sb,
                          input bit ue, input int ext, input bit vld);
        @(negedge clk);
        op_valid  = vld;
        op_code   = 3'(code);
        dst_sel   = AW'(dst);
        srca_sel  = AW'(sa);
        srcb_sel  = AW'(sb);
        use_ext_b = ue;
        ext_data  = W'(ext);
        @(posedge clk);
        @(negedge clk);
        op_valid  = 1'b0;
    endtask

    task automatic rd(input int idx, output int v);
        rd_sel = AW'(idx);
        #1;
        v = int'(rd_data);
    endtask

    function automatic bit exp_cond(input int t, input logic [2:0] f);
        case (t)
            0: return f[2];
            1: return f[1];
            2: return f[0];
            3: return f[2] | f[1];
            4: return f[0] | f[1];
            5: return !f[1];
            default: return 1'b0;
        endcase
    endfunction

    task automatic check_conds(input string req);
        for (int t = 0; t < 8; t++) begin
            cond_sel = 3'(t);
            #1;
            chk(req, int'(cond_true), int'(exp_cond(t, exp_ccr)));
        end
    endtask

    initial begin
        int v, r3_hold;
        exp_ccr = 3'b010;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        for (int i = 0; i < N; i++) begin
            rd(i, v);
            chk("R1 reg reset", v, 0);
        end
        chk("R1 ccr reset", int'(ccr_flags), 2);
        check_conds("R9 conds at reset");

        for (int a = 0; a < M; a++) begin
            for (int b = 0; b < M; b++) begin
                // R5: load through the external operand (R0 stays zero)
                run_op(3, 1, 0, 0, 1'b1, a, 1'b1);
                run_op(3, 2, 0, 0, 1'b1, b, 1'b1);
                rd(1, v); chk("R5 ext load A", v, a);
                rd(2, v); chk("R5 ext load B", v, b);
                chk("R8 ccr kept by OR", int'(ccr_flags), int'(exp_ccr));

                run_op(0, 3, 1, 2, 1'b0, 0, 1'b1);
                rd(3, v); chk("R2 add", v, (a + b) % M);
                chk("R8 ccr kept by ADD", int'(ccr_flags), int'(exp_ccr));
                run_op(1, 3, 1, 2, 1'b0, 0, 1'b1);
                rd(3, v); chk("R3 sub", v, (a - b + M) % M);
                run_op(2, 3, 1, 2, 1'b0, 0, 1'b1);
                rd(3, v); chk("R4 and", v, a & b);
                run_op(3, 3, 1, 2, 1'b0, 0, 1'b1);
                rd(3, v); chk("R4 or", v, a | b);
                run_op(0, 3, 1, 2, 1'b1, b ^ 5, 1'b1);
                rd(3, v); chk("R5 add ext operand", v, (a + (b ^ 5)) % M);
                run_op(4, 3, 1, 2, 1'b0, 0, 1'b1);
                rd(3, v); chk("R4 not", v, (~a) & (M - 1));
                chk("R8 ccr kept by NOT", int'(ccr_flags), int'(exp_ccr));
                r3_hold = v;

                // R6 / R7: compare sets flags, writes nothing
                run_op(5, 3, 1, 2, 1'b0, 0, 1'b1);
                exp_ccr = (a > b) ? 3'b100 : (a == b) ? 3'b010 : 3'b001;
                chk("R6 cmp flags", int'(ccr_flags), int'(exp_ccr));
                rd(3, v); chk("R7 cmp no write", v, r3_hold);
                rd(1, v); chk("R7 cmp src intact", v, a);
                check_conds("R9 cond after cmp");

                // R10: reserved opcode and idle cycle change nothing
                run_op(6 + (b & 1), 3, 1, 2, 1'b0, 0, 1'b1);
                rd(3, v); chk("R10 reserved op no write", v, r3_hold);
                chk("R10 reserved op ccr", int'(ccr_flags), int'(exp_ccr));
                run_op(0, 3, 1, 2, 1'b0, 0, 1'b0);
                rd(3, v); chk("R10 idle no write", v, r3_hold);
                chk("R10 idle ccr", int'(ccr_flags), int'(exp_ccr));
            end
        end

        // R11: result readable right after the capturing edge
        @(negedge clk);
        op_valid = 1'b1; op_code = 3'd3; dst_sel = 2'd3; srca_sel = 2'd0;
        use_ext_b = 1'b1; ext_data = 4'd9; rd_sel = 2'd3;
        @(posedge clk);
        #1;
        op_valid = 1'b0;
        chk("R11 result after edge", int'(rd_data), 9);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule